// File: doc/BRIEF.md
# Supply Supervisor with Watchdog Reset

This block produces the system reset for a processor. It holds reset while the supply is too low. After the supply recovers it keeps reset asserted for a fixed power-up delay. It then watches a chip-select line: any change on that line counts as proof of life. If the line stays quiet for the watchdog period, the block issues a reset of its own.

The two reset pins can be pulled by other circuits on the board, so they are bidirectional. The block senses their levels. An externally caused assertion edge on either pin starts a fresh reset sequence. While an external source keeps holding a pin active, the watchdog does not run. The supply comparator sits outside the block and delivers a flag that is already synchronous to the clock. The two reset outputs are open-drain enables: a 1 means the pad pulls the pin to its active level, and a 0 means the pad floats.

All periods are parameters counted in clock cycles. `DLY_CYC` is the power-up delay and `WDT_CYC` is the watchdog period.

Top module: `reset_supervisor`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, both drive enables are 1 after that edge.
- R2: While `supply_ok` is 0, both drive enables are 1 and the watchdog count stays at zero.
- R3: Take the first edge at which `supply_ok` is sampled 1 after being 0, and count it as edge 1. The drive enables fall to 0 after edge `DLY_CYC`, and no earlier.
- R4: When `supply_ok` falls while reset is released, both drive enables are 1 after the next clock edge.
- R5: While reset is released and the watchdog is running, it counts clock cycles. If `WDT_CYC` cycles pass without a kick, both drive enables rise. The count begins 3 edges after the drive falls. After an expiry, reset is held for `DLY_CYC` cycles and the watchdog then counts again from zero.
- R6: Any change of `cs_in`, from 0 to 1 or from 1 to 0, restarts the watchdog count. The restart takes effect at the third clock edge after the change, because of the two-stage synchronizer and the edge register.
- R7: `rst_hi_drive` and `rst_lo_drive` are always equal.
- R8: While reset is released, a 0-to-1 change on `rst_hi_pin` (active high) asserts both drive enables at the third clock edge after the change. They are then held for `DLY_CYC` cycles.
- R9: While reset is released, a 1-to-0 change on `rst_lo_pin` (active low) has the same effect as in R8.
- R10: If an external source still holds a reset pin active when the `DLY_CYC` hold ends, the drive enables fall anyway. The watchdog then stays cleared until the pin is sensed inactive. It restarts at the third edge after the release.
- R11: Pin transitions caused by the block's own driving never start another reset sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply above trip threshold, synchronous to `clk` |
| cs_in | input | 1 | Chip-select line; any change of it kicks the watchdog |
| rst_hi_pin | input | 1 | Sensed level of the active-high reset pin |
| rst_lo_pin | input | 1 | Sensed level of the active-low reset pin |
| rst_hi_drive | output | 1 | Enable that pulls the active-high pin high |
| rst_lo_drive | output | 1 | Enable that pulls the active-low pin low |

## Verification
The assertions take three things for granted:
- `supply_ok` already arrives synchronous to the clock.
- Each sensed pin reads its active level whenever the block drives it.
- `rst_n` is low at the first clock edge.

The stimulus respects these assumptions. It forms each sensed pin as the OR of the block's own drive and a bench-controlled external pull. It changes every input only on the falling clock edge. It starts the run with `rst_n` low. Random kick gaps are always drawn below the watchdog period, so a reset seen during the random phase can only come from a real fault.

// File: rtl/rsv_pkg.sv
// Package: shared types of the reset supervisor.
// Assumes: nothing beyond the standard.
package rsv_pkg;
    // Sequencer phases
    typedef enum logic [1:0] {
        PH_HOLD    = 2'd0,  // drive reset, count the power-up delay
        PH_SETTLE  = 2'd1,  // released, wait for own pin edges to pass the synchronizer
        PH_EXTWAIT = 2'd2,  // released, an outside source still holds a pin active
        PH_RUN     = 2'd3   // released, watchdog counting
    } phase_t;

    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned SETTLE_CYC  = SYNC_STAGES + 1;
endpackage

// File: rtl/rsv_sync.sv
// Module: rsv_sync
// Multi-stage synchronizer for a vector of independent asynchronous bits.
// Assumes: each bit is sampled on its own; no multi-bit coherence is needed.
module rsv_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] chain [STAGES];

    // Purpose: shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= INIT;
        else        chain[0] <= d_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Purpose: one further metastability-settling stage.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= INIT;
            else        chain[s] <= chain[s-1];
        end
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/rsv_watchdog.sv
// Module: rsv_watchdog
// Counts cycles while enabled. It flags expiry when the count reaches the
// period without a kick.
// Assumes: kick is a one-cycle pulse. The counter is cleared whenever run is low.
module rsv_watchdog #(
    parameter int unsigned WDT_CYC = 320_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic expire
);
    localparam int unsigned CW = $clog2(WDT_CYC + 1);

    logic [CW-1:0] count;

    assign expire = run && !kick && (count == CW'(WDT_CYC - 1));

    // Purpose: advance, clear on kick/stop, wrap on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || kick || expire) count <= '0;
        else                                  count <= count + 1'b1;
    end
endmodule

// File: rtl/rsv_sequencer.sv
// Module: rsv_sequencer
// Reset phase machine. It covers supply loss, the power-up hold, settling after
// release, the external-hold wait and the running phase.
// Assumes: ext_trig and wdog_expire are single-cycle pulses. ext_level is the
// synchronized "some pin is active" level.
module rsv_sequencer
    import rsv_pkg::*;
#(
    parameter int unsigned DLY_CYC = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic ext_trig,
    input  logic ext_level,
    input  logic wdog_expire,
    output logic run,
    output logic assert_rst
);
    localparam int unsigned CW = $clog2(DLY_CYC + SETTLE_CYC + 1);

    phase_t        phase;
    logic [CW-1:0] cnt;

    // Purpose: phase transitions and the shared delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok) begin
            phase <= PH_HOLD;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_HOLD: begin
                    if (cnt == CW'(DLY_CYC - 1)) begin
                        phase <= PH_SETTLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_SETTLE: begin
                    if (cnt == CW'(SETTLE_CYC - 1)) begin
                        phase <= ext_level ? PH_EXTWAIT : PH_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_EXTWAIT: begin
                    if (!ext_level) phase <= PH_RUN;
                end
                PH_RUN: begin
                    if (ext_trig || wdog_expire) begin
                        phase <= PH_HOLD;
                        cnt   <= '0;
                    end
                end
                default: phase <= PH_HOLD;
            endcase
        end
    end

    assign run        = (phase == PH_RUN);
    assign assert_rst = (phase == PH_HOLD);
endmodule

// File: rtl/reset_supervisor.sv
// Module: reset_supervisor (top)
// Supply supervisor with watchdog reset and bidirectional reset pins.
// Assumes: supply_ok is synchronous. cs_in and the pin levels are asynchronous.
// The outputs are open-drain enables.
module reset_supervisor
    import rsv_pkg::*;
#(
    parameter int unsigned DLY_CYC = 30_000_000,
    parameter int unsigned WDT_CYC = 320_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic cs_in,
    input  logic rst_hi_pin,
    input  logic rst_lo_pin,
    output logic rst_hi_drive,
    output logic rst_lo_drive
);
    // bit 0 = cs, bit 1 = high pin, bit 2 = low pin
    localparam logic [2:0] SYNC_INIT = 3'b100;

    logic [2:0] raw_s, synced, prev;
    logic       kick, ext_trig, ext_level, run, expire, assert_rst;

    assign raw_s = {rst_lo_pin, rst_hi_pin, cs_in};

    rsv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(SYNC_INIT)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_s),
        .d_out (synced)
    );

    // Purpose: hold last synchronized values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= SYNC_INIT;
        else        prev <= synced;
    end

    assign kick      = synced[0] ^ prev[0];
    assign ext_trig  = (synced[1] & ~prev[1]) | (~synced[2] & prev[2]);
    assign ext_level = synced[1] | ~synced[2];

    rsv_watchdog #(.WDT_CYC(WDT_CYC)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .kick   (kick),
        .expire (expire)
    );

    rsv_sequencer #(.DLY_CYC(DLY_CYC)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .ext_trig    (ext_trig),
        .ext_level   (ext_level),
        .wdog_expire (expire),
        .run         (run),
        .assert_rst  (assert_rst)
    );

    assign rst_hi_drive = assert_rst;
    assign rst_lo_drive = assert_rst;
endmodule

// File: rtl/rsv_checker.sv
// Module: rsv_checker
// Property checks on the supervisor ports, bound into reset_supervisor.
// Assumes: rst_n is low at the first clock edge.
module rsv_checker #(
    parameter int unsigned DLY_CYC = 30_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic drive_hi,
    input logic drive_lo
);
    localparam int unsigned HW = $clog2(DLY_CYC + 1);

    logic [HW-1:0] held;

    // Purpose: count held reset cycles with good supply, saturating at DLY_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok || !drive_hi) held <= '0;
        else if (held != HW'(DLY_CYC))         held <= held + 1'b1;
    end

    AST_RESET_ASSERTS: assert property (@(posedge clk) !rst_n |=> drive_hi); // R1
    AST_LOW_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> drive_hi); // R2
    AST_HOLD_LONG_ENOUGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_hi) |-> (held == HW'(DLY_CYC) && $past(supply_ok))); // R3
    AST_BROWNOUT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_ok) |=> drive_hi); // R4
    AST_DRIVES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        drive_hi == drive_lo); // R7
endmodule

bind reset_supervisor rsv_checker #(.DLY_CYC(DLY_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .drive_hi  (rst_hi_drive),
    .drive_lo  (rst_lo_drive)
);

// File: tb/reset_supervisor_tb.sv
module reset_supervisor_tb;
    localparam int unsigned DLY = 20;
    localparam int unsigned WDT = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic cs_in = 1'b0;
    logic ext_hi = 1'b0;
    logic ext_lo = 1'b0;
    logic hi_pin, lo_pin, drv_hi, drv_lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // open-drain pins: own drive OR external pull
    assign hi_pin = drv_hi | ext_hi;
    assign lo_pin = ~(drv_lo | ext_lo);

    reset_supervisor #(.DLY_CYC(DLY), .WDT_CYC(WDT)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok    (supply_ok),
        .cs_in        (cs_in),
        .rst_hi_pin   (hi_pin),
        .rst_lo_pin   (lo_pin),
        .rst_hi_drive (drv_hi),
        .rst_lo_drive (drv_lo)
    );

    // expected cycle counts derived from the requirements
    function automatic int exp_wdog_after_release();
        return WDT + 3;  // R5: 3 edges to RUN, then WDT
    endfunction
    function automatic int exp_after_input_change();
        return 3;        // two sync stages plus the edge register
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // cycles (sampled at negedge) until drive reaches level; limit on miss
    task automatic wait_drive(input logic level, input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (drv_hi == level) begin
                check("R7 match", int'(drv_lo), int'(drv_hi));
                return;
            end
        end while (n < limit);
        n = -1;
    endtask

    task automatic idle_check(input int cyc, input string req);
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (drv_hi !== 1'b0) begin
                check(req, int'(drv_hi), 0);
                return;
            end
        end
        check(req, int'(drv_hi), 0);
    endtask

    initial begin : watchdog_timer
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog timeout actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int n;
        void'($urandom(32'd1234));
        // R1: reset asserts drives even with good supply
        supply_ok = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 reset state", int'(drv_hi & drv_lo), 1);
        // R2: supply low keeps reset
        supply_ok = 1'b0;
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        check("R2 supply low", int'(drv_hi & drv_lo), 1);
        // R3: power-up delay
        supply_ok = 1'b1;
        wait_drive(1'b0, 200, n);
        check("R3 power-up delay", n, DLY);
        // R5: expiry with no kicks
        wait_drive(1'b1, 500, n);
        check("R5 expiry time", n, exp_wdog_after_release());
        // R5/R11: hold after expiry, no retrigger from own pin edges
        wait_drive(1'b0, 500, n);
        check("R11 own edges ignored, hold length", n, DLY);
        wait_drive(1'b1, 500, n);
        check("R5 restart from zero", n, exp_wdog_after_release());
        wait_drive(1'b0, 500, n);
        // R6: random kicks shorter than the period keep reset released
        for (int k = 0; k < 60; k++) begin
            int gap;
            gap = 1 + int'($urandom_range(WDT - 5));
            repeat (gap) @(negedge clk);
            if (drv_hi !== 1'b0) check("R6 random kick", int'(drv_hi), 0);
            cs_in = ~cs_in;
        end
        check("R6 random kicks held off", int'(drv_hi), 0);
        wait_drive(1'b1, 500, n);
        check("R6 expiry after last kick", n, exp_after_input_change() + WDT);
        wait_drive(1'b0, 500, n);
        // R4: brown-out in running state
        repeat (10) @(negedge clk);
        supply_ok = 1'b0;
        wait_drive(1'b1, 10, n);
        check("R4 brown-out", n, 1);
        repeat (5) @(negedge clk);
        supply_ok = 1'b1;
        wait_drive(1'b0, 200, n);
        check("R3 recovery delay", n, DLY);
        // R8: external rising edge on high pin
        repeat (7) @(negedge clk);
        ext_hi = 1'b1;
        wait_drive(1'b1, 20, n);
        check("R8 high pin trigger", n, exp_after_input_change());
        repeat (2) @(negedge clk);
        ext_hi = 1'b0;
        wait_drive(1'b0, 200, n);
        check("R8 hold length", n, DLY - 2);
        wait_drive(1'b1, 500, n);
        check("R8 watchdog after", n, exp_wdog_after_release());
        wait_drive(1'b0, 500, n);
        // R9: external falling edge on low pin
        repeat (9) @(negedge clk);
        ext_lo = 1'b1;
        wait_drive(1'b1, 20, n);
        check("R9 low pin trigger", n, exp_after_input_change());
        ext_lo = 1'b0;
        wait_drive(1'b0, 200, n);
        check("R9 hold length", n, DLY);
        // R10: external hold longer than the delay
        repeat (4) @(negedge clk);
        ext_hi = 1'b1;
        wait_drive(1'b1, 20, n);
        check("R10 trigger", n, exp_after_input_change());
        wait_drive(1'b0, 200, n);
        check("R10 release while held", n, DLY);
        idle_check(3 * WDT, "R10 watchdog held during external hold");
        ext_hi = 1'b0;
        wait_drive(1'b1, 500, n);
        check("R10 watchdog after external release", n, exp_after_input_change() + WDT);
        // R1: reset in the middle of run
        wait_drive(1'b0, 200, n);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", int'(drv_hi), 1);
        rst_n = 1'b1;
        wait_drive(1'b0, 200, n);
        check("R3 after reset", n, DLY);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule